// File: doc/BRIEF.md
# USB Link State Monitor

This block follows the condition of a USB device link from line observations alone. Each clock it takes the sampled bus level (SE0, idle J, or K), the VBUS sense bit, a strobe from the packet layer that says a start-of-frame token was received, a link enable bit and a one-cycle software resume request. Several run-length timers work on these inputs at the same time. From them the block keeps a link state and raises single-cycle event pulses for disconnect, bus reset, suspend, resume and loss of the host.

The interrupt logic consumes the event pulses. Software reads the link state. All thresholds are counted in cycles of the 48 MHz clock and are parameters. The defaults are 120 cycles for a bus reset (2.5 µs), 144000 for suspend (3 ms), 196608 for the first host-lost report (4.096 ms) and 48000 for each repeat (1 ms). Packet decoding happens elsewhere.

Top module: `usb_link_monitor`

## Requirements
- R1: While enabled, VBUS sense low moves the link to Disconnected at the next clock edge. A one-cycle disconnect pulse is raised only when the state before was not already Disconnected.
- R2: RESET_CYCLES consecutive samples of SE0 on a connected link move the state to Active and raise one bus-reset pulse, registered on the edge that takes the last of those samples. A shorter run raises nothing, and a run raises at most one pulse however long it lasts.
- R3: SUSPEND_CYCLES consecutive samples of J move Powered to PoweredSuspended, and Active to Suspended, with one suspend pulse on the edge that takes the last sample. A longer run raises no further pulse.
- R4: In PoweredSuspended or Suspended, any sample that is not J returns the link to Powered or Active respectively on that edge, with one resume pulse.
- R5: In Active, HOST_LOST_CYCLES clock edges without a start-of-frame strobe raise a host-lost pulse. After that the pulse repeats every HOST_LOST_REPEAT edges. A strobe restarts the full HOST_LOST_CYCLES window. No host-lost pulse occurs outside Active.
- R6: A resume request moves the link to Resuming only from Powered. It is ignored in every other state. In Resuming, the first J seen after a K moves the link to Active with one resume pulse.
- R7: Enable low forces Disconnected at the next edge and raises no disconnect pulse. In Disconnected, with enable and VBUS both high, the link moves to Powered at the next edge.
- R8: The state codes are Disconnected 0, Powered 1, PoweredSuspended 2, Active 3, Suspended 4 and Resuming 5. The line codes are SE0 0, J 1, K 2, and 3 counts as activity that is neither J nor SE0. Under reset the state is Disconnected and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48 MHz clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Link enable; low forces Disconnected |
| vbus_sense_i | input | 1 | VBUS present |
| line_i | input | 2 | Sampled bus level (0 SE0, 1 J, 2 K, 3 other) |
| sof_i | input | 1 | Start-of-frame received strobe |
| resume_req_i | input | 1 | Software request to start resume signalling |
| link_state_o | output | 3 | Current link state code |
| ev_disconnect_o | output | 1 | Disconnect pulse |
| ev_bus_reset_o | output | 1 | Bus-reset pulse |
| ev_suspend_o | output | 1 | Suspend pulse |
| ev_resume_o | output | 1 | Resume pulse |
| ev_host_lost_o | output | 1 | Host-lost pulse |

## Verification
A corrupted state register shows on link_state_o at the next edge. If it took the wrong transition, the wrong event pulse, or a missing one, appears in that same cycle. A run timer that is off by even one count moves the reset or suspend pulse by one cycle, so every threshold is probed one cycle before it is reached and on the cycle it is reached. A fault in the host-lost watchdog's restart only shows a full window later, so the bench waits out the first window, a repeat interval, and a window restarted by a strobe.

// File: rtl/usb_link_pkg.sv
package usb_link_pkg;

    typedef enum logic [2:0] {
        LS_DISCONNECTED = 3'd0,
        LS_POWERED      = 3'd1,
        LS_POWERED_SUSP = 3'd2,
        LS_ACTIVE       = 3'd3,
        LS_SUSPENDED    = 3'd4,
        LS_RESUMING     = 3'd5
    } link_state_e;

    typedef enum logic [1:0] {
        LINE_SE0 = 2'd0,
        LINE_J   = 2'd1,
        LINE_K   = 2'd2,
        LINE_SE1 = 2'd3
    } line_level_e;

    typedef struct packed {
        logic disconnect;
        logic bus_reset;
        logic suspend;
        logic resume;
        logic host_lost;
    } link_events_t;

    // index of each run timer inside the generated bank
    localparam int unsigned RUN_SE0  = 0;
    localparam int unsigned RUN_IDLE = 1;
    localparam int unsigned RUN_NUM  = 2;

endpackage

// File: rtl/ulm_run_timer.sv
// Counts consecutive cycles of a level; hit_o marks the cycle that completes
// THRESHOLD samples. The counter saturates, so one run gives one hit.
module ulm_run_timer #(
    parameter int unsigned THRESHOLD = 120
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clear_i,
    input  logic level_i,
    output logic hit_o
);
    localparam int unsigned CW = $clog2(THRESHOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(THRESHOLD);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_regs_t;

    run_regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        hit_o = 1'b0;
        if (clear_i || !level_i) begin
            r_d.cnt = '0;
        end else if (r_q.cnt < LIMIT) begin
            r_d.cnt = r_q.cnt + 1'b1;
            hit_o   = (r_q.cnt == LIMIT - 1'b1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // one pulse per run (serves R2 and R3)
    assert_single_hit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_o |=> !hit_o);

endmodule

// File: rtl/ulm_sof_watchdog.sv
// Counts edges in the active state without a frame strobe; reports the first
// loss after FIRST_CYCLES and then every REPEAT_CYCLES.
module ulm_sof_watchdog #(
    parameter int unsigned FIRST_CYCLES  = 196608,
    parameter int unsigned REPEAT_CYCLES = 48000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic sof_i,
    output logic lost_o
);
    localparam int unsigned MAXC = (FIRST_CYCLES > REPEAT_CYCLES) ? FIRST_CYCLES : REPEAT_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] FIRST_LIM  = CW'(FIRST_CYCLES);
    localparam logic [CW-1:0] REPEAT_LIM = CW'(REPEAT_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lost;
    } wd_regs_t;

    wd_regs_t      r_d, r_q;
    logic [CW-1:0] limit;

    always_comb begin
        r_d    = r_q;
        lost_o = 1'b0;
        limit  = r_q.lost ? REPEAT_LIM : FIRST_LIM;
        if (!active_i || sof_i) begin
            r_d.cnt  = '0;
            r_d.lost = 1'b0;
        end else if (r_q.cnt == limit - 1'b1) begin
            r_d.cnt  = '0;
            r_d.lost = 1'b1;
            lost_o   = 1'b1;
        end else begin
            r_d.cnt = r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    generate
        if (FIRST_CYCLES > 1) begin : g_sof_chk
            assert_sof_restarts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
                sof_i |=> !lost_o);
        end
    endgenerate

endmodule

// File: rtl/usb_link_monitor.sv
module usb_link_monitor
    import usb_link_pkg::*;
#(
    parameter int unsigned RESET_CYCLES     = 120,
    parameter int unsigned SUSPEND_CYCLES   = 144000,
    parameter int unsigned HOST_LOST_CYCLES = 196608,
    parameter int unsigned HOST_LOST_REPEAT = 48000
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic       vbus_sense_i,
    input  logic [1:0] line_i,
    input  logic       sof_i,
    input  logic       resume_req_i,
    output logic [2:0] link_state_o,
    output logic       ev_disconnect_o,
    output logic       ev_bus_reset_o,
    output logic       ev_suspend_o,
    output logic       ev_resume_o,
    output logic       ev_host_lost_o
);
    localparam int unsigned RUN_THR [RUN_NUM] = '{RESET_CYCLES, SUSPEND_CYCLES};

    typedef struct packed {
        link_state_e  state;
        logic         seen_k;
        link_events_t ev;
    } mon_regs_t;

    mon_regs_t          r_d, r_q;
    logic [RUN_NUM-1:0] run_level;
    logic [RUN_NUM-1:0] run_hit;
    logic               run_clear;
    logic               host_lost;
    line_level_e        line;

    assign line      = line_level_e'(line_i);
    assign run_clear = !enable_i || !vbus_sense_i || (r_q.state == LS_DISCONNECTED);
    assign run_level[RUN_SE0]  = (line == LINE_SE0);
    assign run_level[RUN_IDLE] = (line == LINE_J);

    generate
        for (genvar g = 0; g < RUN_NUM; g++) begin : g_run
            ulm_run_timer #(
                .THRESHOLD(RUN_THR[g])
            ) i_run (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .clear_i(run_clear),
                .level_i(run_level[g]),
                .hit_o  (run_hit[g])
            );
        end
    endgenerate

    ulm_sof_watchdog #(
        .FIRST_CYCLES (HOST_LOST_CYCLES),
        .REPEAT_CYCLES(HOST_LOST_REPEAT)
    ) i_sof_wd (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .active_i(r_q.state == LS_ACTIVE),
        .sof_i   (sof_i),
        .lost_o  (host_lost)
    );

    always_comb begin
        r_d    = r_q;
        r_d.ev = '0;
        if (!enable_i) begin
            r_d.state  = LS_DISCONNECTED;
            r_d.seen_k = 1'b0;
        end else if (!vbus_sense_i) begin
            r_d.ev.disconnect = (r_q.state != LS_DISCONNECTED);
            r_d.state         = LS_DISCONNECTED;
            r_d.seen_k        = 1'b0;
        end else if (r_q.state == LS_DISCONNECTED) begin
            r_d.state = LS_POWERED;
        end else if (run_hit[RUN_SE0]) begin
            r_d.state        = LS_ACTIVE;
            r_d.seen_k       = 1'b0;
            r_d.ev.bus_reset = 1'b1;
        end else begin
            unique case (r_q.state)
                LS_POWERED: begin
                    if (run_hit[RUN_IDLE]) begin
                        r_d.state      = LS_POWERED_SUSP;
                        r_d.ev.suspend = 1'b1;
                    end else if (resume_req_i) begin
                        r_d.state  = LS_RESUMING;
                        r_d.seen_k = 1'b0;
                    end
                end
                LS_ACTIVE: begin
                    if (run_hit[RUN_IDLE]) begin
                        r_d.state      = LS_SUSPENDED;
                        r_d.ev.suspend = 1'b1;
                    end
                end
                LS_POWERED_SUSP: begin
                    if (line != LINE_J) begin
                        r_d.state     = LS_POWERED;
                        r_d.ev.resume = 1'b1;
                    end
                end
                LS_SUSPENDED: begin
                    if (line != LINE_J) begin
                        r_d.state     = LS_ACTIVE;
                        r_d.ev.resume = 1'b1;
                    end
                end
                LS_RESUMING: begin
                    if (line == LINE_K) begin
                        r_d.seen_k = 1'b1;
                    end else if (line == LINE_J && r_q.seen_k) begin
                        r_d.state     = LS_ACTIVE;
                        r_d.seen_k    = 1'b0;
                        r_d.ev.resume = 1'b1;
                    end
                end
                default: r_d.state = LS_DISCONNECTED;
            endcase
        end
        r_d.ev.host_lost = host_lost;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '{state: LS_DISCONNECTED, seen_k: 1'b0, ev: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign link_state_o    = r_q.state;
    assign ev_disconnect_o = r_q.ev.disconnect;
    assign ev_bus_reset_o  = r_q.ev.bus_reset;
    assign ev_suspend_o    = r_q.ev.suspend;
    assign ev_resume_o     = r_q.ev.resume;
    assign ev_host_lost_o  = r_q.ev.host_lost;

    assert_vbus_drop_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (enable_i && !vbus_sense_i) |=> (link_state_o == LS_DISCONNECTED));

    assert_disc_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_disconnect_o |-> (link_state_o == LS_DISCONNECTED) && ($past(link_state_o) != LS_DISCONNECTED));

    assert_reset_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_bus_reset_o |-> (link_state_o == LS_ACTIVE));

    assert_suspend_state_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_suspend_o |-> (link_state_o == LS_SUSPENDED || link_state_o == LS_POWERED_SUSP));

    assert_resume_state_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_resume_o |-> (link_state_o == LS_ACTIVE || link_state_o == LS_POWERED));

    assert_lost_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_host_lost_o |-> ($past(link_state_o) == LS_ACTIVE));

    assert_resume_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (link_state_o == LS_RESUMING && $past(link_state_o) != LS_RESUMING)
            |-> ($past(link_state_o) == LS_POWERED));

    assert_disable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !enable_i |=> (link_state_o == LS_DISCONNECTED) && !ev_disconnect_o);

endmodule

// File: tb/test_usb_link_monitor.sv
module test_usb_link_monitor;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned T_RST  = 8;
    localparam int unsigned T_SUSP = 40;
    localparam int unsigned T_HL   = 30;
    localparam int unsigned T_REP  = 12;

    // line codes and state codes from R8
    localparam logic [1:0] SE0 = 2'd0, LJ = 2'd1, LK = 2'd2;
    localparam logic [2:0] S_DIS = 3'd0, S_PWR = 3'd1, S_PSU = 3'd2,
                           S_ACT = 3'd3, S_SUS = 3'd4, S_RSM = 3'd5;
    // expected event bits: [0] disconnect [1] reset [2] suspend [3] resume [4] host lost
    localparam logic [4:0] E0 = 5'b00000, E_DIS = 5'b00001, E_RST = 5'b00010,
                           E_SUS = 5'b00100, E_RES = 5'b01000, E_HL = 5'b10000;

    typedef struct packed {
        logic       en;
        logic       vbus;
        logic [1:0] line;
        logic       sof;
        logic       rreq;
        logic [7:0] cyc;
        logic [3:0] req;
        logic [2:0] st;
        logic [4:0] ev;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, LJ,  1'b0, 1'b0, 8'd3,  4'd7, S_DIS, E0},    // R7 disabled
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd7, S_PWR, E0},    // R7 power up
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd39, 4'd3, S_PWR, E0},    // R3 one short
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd3, S_PSU, E_SUS}, // R3 powered suspend
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd1,  4'd4, S_PWR, E_RES}, // R4
        '{1'b1, 1'b1, LJ,  1'b0, 1'b1, 8'd1,  4'd6, S_RSM, E0},    // R6 request in Powered
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd2,  4'd6, S_RSM, E0},    // R6 K seen
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd6, S_ACT, E_RES}, // R6 J after K
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd29, 4'd5, S_ACT, E0},    // R5 window minus one
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd1,  4'd5, S_ACT, E_HL},  // R5 first loss
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd11, 4'd5, S_ACT, E0},
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd1,  4'd5, S_ACT, E_HL},  // R5 repeat
        '{1'b1, 1'b1, LK,  1'b1, 1'b0, 8'd1,  4'd5, S_ACT, E0},    // R5 strobe
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd29, 4'd5, S_ACT, E0},
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd1,  4'd5, S_ACT, E_HL},  // R5 full window again
        '{1'b1, 1'b1, SE0, 1'b1, 1'b0, 8'd7,  4'd2, S_ACT, E0},    // R2 one short
        '{1'b1, 1'b1, SE0, 1'b0, 1'b0, 8'd1,  4'd2, S_ACT, E_RST}, // R2 reset in Active
        '{1'b1, 1'b1, LJ,  1'b1, 1'b0, 8'd39, 4'd3, S_ACT, E0},
        '{1'b1, 1'b1, LJ,  1'b1, 1'b0, 8'd1,  4'd3, S_SUS, E_SUS}, // R3 suspend from Active
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd50, 4'd3, S_SUS, E0},    // R3 no repeat, R5 quiet
        '{1'b1, 1'b1, LK,  1'b0, 1'b0, 8'd1,  4'd4, S_ACT, E_RES}, // R4 from Suspended
        '{1'b1, 1'b1, LK,  1'b0, 1'b1, 8'd2,  4'd6, S_ACT, E0},    // R6 ignored in Active
        '{1'b1, 1'b0, LK,  1'b0, 1'b0, 8'd1,  4'd1, S_DIS, E_DIS}, // R1 drop
        '{1'b1, 1'b0, LK,  1'b0, 1'b0, 8'd3,  4'd1, S_DIS, E0},    // R1 single pulse
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd7, S_PWR, E0},
        '{1'b1, 1'b1, SE0, 1'b0, 1'b0, 8'd7,  4'd2, S_PWR, E0},
        '{1'b1, 1'b1, SE0, 1'b0, 1'b0, 8'd1,  4'd2, S_ACT, E_RST}, // R2 from Powered
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd2, S_ACT, E0},
        '{1'b1, 1'b1, SE0, 1'b0, 1'b0, 8'd7,  4'd2, S_ACT, E0},    // R2 short run
        '{1'b1, 1'b1, LJ,  1'b0, 1'b0, 8'd1,  4'd2, S_ACT, E0},
        '{1'b1, 1'b1, SE0, 1'b0, 1'b0, 8'd7,  4'd2, S_ACT, E0},    // R2 short run
        '{1'b0, 1'b1, LK,  1'b0, 1'b0, 8'd2,  4'd7, S_DIS, E0}     // R7 disable, no pulse
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, vbus = 1'b0, sof = 1'b0, rreq = 1'b0;
    logic [1:0] line = 2'd1;
    logic [2:0] state;
    logic       e_dis, e_rst, e_sus, e_res, e_hl;
    int         checks = 0;
    int         errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    usb_link_monitor #(
        .RESET_CYCLES    (T_RST),
        .SUSPEND_CYCLES  (T_SUSP),
        .HOST_LOST_CYCLES(T_HL),
        .HOST_LOST_REPEAT(T_REP)
    ) i_usb_link_monitor (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (en),
        .vbus_sense_i   (vbus),
        .line_i         (line),
        .sof_i          (sof),
        .resume_req_i   (rreq),
        .link_state_o   (state),
        .ev_disconnect_o(e_dis),
        .ev_bus_reset_o (e_rst),
        .ev_suspend_o   (e_sus),
        .ev_resume_o    (e_res),
        .ev_host_lost_o (e_hl)
    );

    task automatic check(input int req, input int idx, input logic [2:0] exp_st, input logic [4:0] exp_ev);
        logic [4:0] got;
        got = {e_hl, e_res, e_sus, e_rst, e_dis};
        checks++;
        if (state !== exp_st || got !== exp_ev) begin
            errors++;
            $display("FAIL R%0d step %0d: state=%0d events=%b, expected state=%0d events=%b",
                     req, idx, state, got, exp_st, exp_ev);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, got timeout, expected end of stimulus");
        finish_run();
    end

    initial begin
        // R8 reset state
        repeat (3) @(negedge clk);
        check(8, -1, S_DIS, E0);
        rst_n = 1'b1;
        @(negedge clk);
        check(8, -2, S_DIS, E0);
        for (int i = 0; i < NV; i++) begin
            en   = VECS[i].en;
            vbus = VECS[i].vbus;
            line = VECS[i].line;
            sof  = VECS[i].sof;
            rreq = VECS[i].rreq;
            for (int c = 1; c <= int'(VECS[i].cyc); c++) begin
                @(posedge clk);
                @(negedge clk);
                if (c == int'(VECS[i].cyc))
                    check(int'(VECS[i].req), i, VECS[i].st, VECS[i].ev);
                else
                    check(int'(VECS[i].req), i, VECS[i].st, E0);
            end
        end
        // R8 reset in mid-operation returns to Disconnected with no pulses
        en = 1'b1; vbus = 1'b1; line = LJ;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(8, -3, S_DIS, E0);
        finish_run();
    end

endmodule